// File: doc/BRIEF.md
# Bitmask Dictionary Code Decompressor

This block expands a serial stream of variable-length codewords back into fixed-width data vectors. It produces one vector per output beat. A two-entry dictionary holds the most common vectors. Each codeword names a dictionary entry to use as is, names an entry together with a small 2-bit XOR correction placed in one aligned slot, or carries the vector verbatim. Compressed program images usually sit between a memory and a consumer such as a fetch unit. The consumer sees only the rebuilt vectors.

Software or a loader fills the dictionary through a plain write port while no codeword is in flight. Codeword bits then stream in one at a time under a valid/ready handshake. Each rebuilt vector enters a four-entry output queue, and a valid/ready handshake carries it downstream. When the queue is full, the serial input is stalled, so no vector is ever dropped.

Top module: `bmdict_decomp`

## Requirements
- R1: A synchronous reset empties the output queue (outValid low, inReady high on the next cycle) and discards any partly received codeword. It leaves both dictionary entries unchanged.
- R2: A codeword whose first bit is 1 is a literal. The next 8 bits, most significant first, are the output vector.
- R3: The bit sequence 0, 1, i (3 bits) outputs dictionary entry i.
- R4: The bit sequence 0, 0, i, p1, p0, m1, m0 (7 bits) outputs dictionary entry i XOR the 2-bit pattern {m1,m0} placed in the slot selected by {p1,p0}.
- R5: Slot value 0 covers bits 1:0, value 1 covers bits 3:2, value 2 covers bits 5:4, and value 3 covers bits 7:6.
- R6: An input bit is consumed only in a cycle where inValid and inReady are both high. Codewords may follow each other with no gap and with any number of idle cycles between bits.
- R7: The output queue holds 4 vectors and delivers them in arrival order. While 4 vectors are stored, inReady is low and no vector is lost.
- R8: While outValid is high and outReady is low, outValid stays high and outData stays unchanged.
- R9: A dictionary write (dictWrEn high for one cycle) takes effect only when no codeword is partly received. A write issued in the middle of a codeword is ignored.
- R10: When the queue is empty, the rebuilt vector appears on outValid/outData in the cycle after the cycle that accepts the last bit of its codeword.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| dictWrEn | input | 1 | Dictionary write strobe |
| dictWrIdx | input | 1 | Dictionary entry being written |
| dictWrData | input | 8 | Value to store in the dictionary |
| inValid | input | 1 | Serial codeword bit is valid |
| inBit | input | 1 | Serial codeword bit, fields most significant first |
| inReady | output | 1 | Decoder can take a bit this cycle |
| outValid | output | 1 | Head of the output queue is valid |
| outReady | input | 1 | Downstream takes the head vector |
| outData | output | 8 | Rebuilt vector |

## Verification
A wrong decoder state or a miscounted field shows up at the first vector emitted after the fault. That vector has the wrong value, or it arrives too early or too late, and every later codeword then loses alignment, so the error spreads and cannot go unseen. A queue pointer or count fault shows up as a reordered, repeated or missing vector, or as a wrong inReady when the queue holds four entries. A dictionary write that lands mid-codeword changes the very next exact or masked vector. Each of these faults therefore reaches the output within one codeword of its cause.

// File: rtl/bmd_pkg.sv
package bmd_pkg;

  typedef enum logic [2:0] {
    ST_FLAG,
    ST_MODE,
    ST_INDEX,
    ST_POS,
    ST_PAT,
    ST_LIT
  } bmdState_e;

  typedef enum logic [1:0] {
    SRC_NONE,
    SRC_EXACT,
    SRC_MASK,
    SRC_LIT
  } bmdSrc_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    capIdx;   // shift a dictionary index bit
    logic    shPos;    // shift a slot position bit
    logic    shPat;    // shift a mask pattern bit
    logic    shLit;    // shift a literal bit
    bmdSrc_e emit;     // which rebuilt vector to push this cycle
    logic    dictOpen; // decoder between codewords
  } bmdStrobe_t;

endpackage

// File: rtl/bmd_ctrl.sv
module bmd_ctrl
  import bmd_pkg::*;
#(
  parameter int VEC_W = 8,
  parameter int IDX_W = 1,
  parameter int POS_W = 2,
  parameter int MASK_W = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  input  logic       inBit,
  input  logic       queueFull,
  output logic       inReady,
  output bmdStrobe_t strb
);

  localparam int CNT_W = (VEC_W > 1) ? $clog2(VEC_W) : 1;

  bmdState_e state, stNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic exactMode, exactNext;
  logic take;

  assign inReady = !queueFull;
  assign take = inValid && inReady;

  always_comb begin
    stNext = state;
    cntNext = cnt;
    exactNext = exactMode;
    strb.capIdx = 1'b0;
    strb.shPos = 1'b0;
    strb.shPat = 1'b0;
    strb.shLit = 1'b0;
    strb.emit = SRC_NONE;
    strb.dictOpen = (state == ST_FLAG);
    if (take) begin
      case (state)
        ST_FLAG: begin
          cntNext = '0;
          stNext = inBit ? ST_LIT : ST_MODE;
        end
        ST_MODE: begin
          exactNext = inBit;
          cntNext = '0;
          stNext = ST_INDEX;
        end
        ST_INDEX: begin
          strb.capIdx = 1'b1;
          if (cnt == CNT_W'(IDX_W - 1)) begin
            cntNext = '0;
            if (exactMode) begin
              strb.emit = SRC_EXACT;
              stNext = ST_FLAG;
            end else begin
              stNext = ST_POS;
            end
          end else begin
            cntNext = cnt + 1'b1;
          end
        end
        ST_POS: begin
          strb.shPos = 1'b1;
          if (cnt == CNT_W'(POS_W - 1)) begin
            cntNext = '0;
            stNext = ST_PAT;
          end else begin
            cntNext = cnt + 1'b1;
          end
        end
        ST_PAT: begin
          strb.shPat = 1'b1;
          if (cnt == CNT_W'(MASK_W - 1)) begin
            cntNext = '0;
            strb.emit = SRC_MASK;
            stNext = ST_FLAG;
          end else begin
            cntNext = cnt + 1'b1;
          end
        end
        ST_LIT: begin
          strb.shLit = 1'b1;
          if (cnt == CNT_W'(VEC_W - 1)) begin
            cntNext = '0;
            strb.emit = SRC_LIT;
            stNext = ST_FLAG;
          end else begin
            cntNext = cnt + 1'b1;
          end
        end
        default: stNext = ST_FLAG;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_FLAG;
      cnt <= '0;
      exactMode <= 1'b0;
    end else begin
      state <= stNext;
      cnt <= cntNext;
      exactMode <= exactNext;
    end
  end

endmodule

// File: rtl/bmd_datapath.sv
module bmd_datapath
  import bmd_pkg::*;
#(
  parameter int VEC_W = 8,
  parameter int DICT_N = 2,
  parameter int MASK_W = 2
) (
  input  logic                      clk,
  input  bmdStrobe_t                strb,
  input  logic                      inBit,
  input  logic                      dictWrEn,
  input  logic [$clog2(DICT_N)-1:0] dictWrIdx,
  input  logic [VEC_W-1:0]          dictWrData,
  output logic                      pushEn,
  output logic [VEC_W-1:0]          pushData
);

  localparam int IDX_W = $clog2(DICT_N);
  localparam int SLOTS = VEC_W / MASK_W;
  localparam int POS_W = $clog2(SLOTS);

  logic [VEC_W-1:0]  dictMem [DICT_N];
  logic [IDX_W-1:0]  idxReg, idxNext;
  logic [POS_W-1:0]  posReg;
  logic [MASK_W-1:0] patReg, patNext;
  logic [VEC_W-1:0]  litReg, litNext;
  logic [VEC_W-1:0]  maskVec;

  assign idxNext = IDX_W'({idxReg, inBit});
  assign patNext = MASK_W'({patReg, inBit});
  assign litNext = VEC_W'({litReg, inBit});

  always_ff @(posedge clk) begin
    if (dictWrEn && strb.dictOpen) dictMem[dictWrIdx] <= dictWrData;
    if (strb.capIdx) idxReg <= idxNext;
    if (strb.shPos) posReg <= POS_W'({posReg, inBit});
    if (strb.shPat) patReg <= patNext;
    if (strb.shLit) litReg <= litNext;
  end

  // place the pattern in the slot picked by the position field
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    assign maskVec[s*MASK_W +: MASK_W] = (posReg == POS_W'(s)) ? patNext : '0;
  end

  assign pushEn = (strb.emit != SRC_NONE);

  always_comb begin
    case (strb.emit)
      SRC_EXACT: pushData = dictMem[idxNext];
      SRC_MASK:  pushData = dictMem[idxReg] ^ maskVec;
      SRC_LIT:   pushData = litNext;
      default:   pushData = '0;
    endcase
  end

endmodule

// File: rtl/bmd_queue.sv
module bmd_queue #(
  parameter int W = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         pushEn,
  input  logic [W-1:0] pushData,
  input  logic         popReady,
  output logic         outValid,
  output logic [W-1:0] outData,
  output logic         full
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count;
  logic doPush, doPop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full = (count == CW'(DEPTH));
  assign outValid = (count != '0);
  assign outData = mem[rdPtr];
  assign doPush = pushEn && !full;
  assign doPop = popReady && outValid;

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= bump(wrPtr);
      if (doPop) rdPtr <= bump(rdPtr);
      count <= count + CW'(doPush) - CW'(doPop);
    end
  end

endmodule

// File: rtl/bmdict_decomp.sv
module bmdict_decomp
  import bmd_pkg::*;
#(
  parameter int VEC_W = 8,
  parameter int DICT_N = 2,
  parameter int MASK_W = 2,
  parameter int QUEUE_DEPTH = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      dictWrEn,
  input  logic [$clog2(DICT_N)-1:0] dictWrIdx,
  input  logic [VEC_W-1:0]          dictWrData,
  input  logic                      inValid,
  input  logic                      inBit,
  output logic                      inReady,
  output logic                      outValid,
  input  logic                      outReady,
  output logic [VEC_W-1:0]          outData
);

  localparam int IDX_W = $clog2(DICT_N);
  localparam int POS_W = $clog2(VEC_W / MASK_W);

  bmdStrobe_t strb;
  logic qFull;
  logic qPush;
  logic [VEC_W-1:0] pushData;

  bmd_ctrl #(
    .VEC_W(VEC_W), .IDX_W(IDX_W), .POS_W(POS_W), .MASK_W(MASK_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .inBit(inBit),
    .queueFull(qFull), .inReady(inReady), .strb(strb)
  );

  bmd_datapath #(
    .VEC_W(VEC_W), .DICT_N(DICT_N), .MASK_W(MASK_W)
  ) u_dp (
    .clk(clk), .strb(strb), .inBit(inBit), .dictWrEn(dictWrEn),
    .dictWrIdx(dictWrIdx), .dictWrData(dictWrData),
    .pushEn(qPush), .pushData(pushData)
  );

  bmd_queue #(
    .W(VEC_W), .DEPTH(QUEUE_DEPTH)
  ) u_queue (
    .clk(clk), .rst(rst), .pushEn(qPush), .pushData(pushData),
    .popReady(outReady), .outValid(outValid), .outData(outData),
    .full(qFull)
  );

endmodule

// File: rtl/bmd_checker.sv
module bmd_checker #(
  parameter int VEC_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             inReady,
  input logic             outValid,
  input logic             outReady,
  input logic [VEC_W-1:0] outData,
  input logic             qFull,
  input logic             qPush
);

  a_r1_reset_empty: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!outValid && inReady));

  a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
    qPush |-> !qFull);

  a_r7_stall_full: assert property (@(posedge clk) disable iff (rst)
    qFull |-> !inReady);

  a_r8_hold_out: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

  a_r10_push_visible: assert property (@(posedge clk) disable iff (rst)
    qPush |=> outValid);

endmodule

bind bmdict_decomp bmd_checker #(.VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst(rst), .inReady(inReady), .outValid(outValid),
  .outReady(outReady), .outData(outData), .qFull(qFull), .qPush(qPush)
);

// File: tb/bmdict_decomp_tb.sv
`timescale 1ns/1ps
module bmdict_decomp_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dictWrEn = 1'b0;
  logic [0:0] dictWrIdx = '0;
  logic [7:0] dictWrData = '0;
  logic inValid = 1'b0;
  logic inBit = 1'b0;
  logic inReady;
  logic outValid;
  logic outReady = 1'b0;
  logic [7:0] outData;

  int testCount = 0;
  int failCount = 0;
  int readyMode = 0;   // 0 stall, 1 always ready, 2 random
  bit gapMode = 0;
  logic [7:0] dictModel [2];
  logic [7:0] expQ [$];
  string tagQ [$];

  always #2 clk = ~clk;

  bmdict_decomp u_dut (
    .clk(clk), .rst(rst), .dictWrEn(dictWrEn), .dictWrIdx(dictWrIdx),
    .dictWrData(dictWrData), .inValid(inValid), .inBit(inBit),
    .inReady(inReady), .outValid(outValid), .outReady(outReady),
    .outData(outData)
  );

  task automatic checkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: scoreboard pop on each output transfer
  always begin
    @(negedge clk);
    case (readyMode)
      0: outReady = 1'b0;
      1: outReady = 1'b1;
      default: outReady = ($urandom % 3) != 0;
    endcase
    if (outValid && outReady) begin
      if (expQ.size() == 0) begin
        testCount++;
        failCount++;
        $display("FAIL R7: actual %0h expected none (unexpected output)", outData);
      end else begin
        checkEq(tagQ.pop_front(), {24'd0, outData}, {24'd0, expQ.pop_front()});
      end
    end
  end

  task automatic sendBit(input logic b);
    if (gapMode && ($urandom % 4) == 0) @(negedge clk);
    inBit = b;
    inValid = 1'b1;
    while (!inReady) @(negedge clk);
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic dictWrite(input logic idx, input logic [7:0] val, input bit idle);
    dictWrEn = 1'b1;
    dictWrIdx = idx;
    dictWrData = val;
    @(negedge clk);
    dictWrEn = 1'b0;
    if (idle) dictModel[idx] = val;
  endtask

  // reference encoder: exact, then one-slot mask, else literal
  task automatic sendVec(input logic [7:0] v, input string tagIn);
    logic bits [$];
    string tag;
    bit done;
    done = 0;
    for (int i = 0; i < 2 && !done; i++) begin
      if (v == dictModel[i]) begin
        bits = '{1'b0, 1'b1, 1'(i)};
        tag = "R3";
        done = 1;
      end
    end
    for (int i = 0; i < 2 && !done; i++) begin
      for (int p = 0; p < 4 && !done; p++) begin
        logic [7:0] d;
        logic [1:0] pat;
        d = v ^ dictModel[i];
        pat = d[2*p +: 2];
        if ((d & ~(8'h03 << (2*p))) == 8'h00) begin
          bits = '{1'b0, 1'b0, 1'(i), 1'(p >> 1), 1'(p), pat[1], pat[0]};
          tag = "R4";
          done = 1;
        end
      end
    end
    if (!done) begin
      bits.push_back(1'b1);
      for (int k = 7; k >= 0; k--) bits.push_back(v[k]);
      tag = "R2";
    end
    if (tagIn != "") tag = tagIn;
    expQ.push_back(v);
    tagQ.push_back(tag);
    foreach (bits[k]) sendBit(bits[k]);
  endtask

  task automatic drain();
    readyMode = 1;
    while (expQ.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic doReset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    testCount++;
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    logic [7:0] held;
    @(negedge clk);
    doReset();
    // R1: reset state
    checkEq("R1 outValid after reset", {31'd0, outValid}, 32'd0);
    checkEq("R1 inReady after reset", {31'd0, inReady}, 32'd1);

    dictWrite(1'b0, 8'hA5, 1);
    dictWrite(1'b1, 8'h3C, 1);

    // R10 latency with stalled output
    readyMode = 0;
    @(negedge clk);
    sendBit(1'b0);
    sendBit(1'b1);
    checkEq("R10 no early output", {31'd0, outValid}, 32'd0);
    expQ.push_back(8'h3C);
    tagQ.push_back("R3");
    sendBit(1'b1);
    checkEq("R10 output one cycle after last bit", {31'd0, outValid}, 32'd1);
    checkEq("R10 output value", {24'd0, outData}, 32'h3C);

    // R8 hold under backpressure
    held = outData;
    repeat (3) @(negedge clk);
    checkEq("R8 valid held", {31'd0, outValid}, 32'd1);
    checkEq("R8 data held", {24'd0, outData}, {24'd0, held});

    // R7: fill the queue
    sendVec(8'hA5, "R7");
    sendVec(8'h00, "R7");
    sendVec(8'hA5 ^ 8'h30, "R7");
    checkEq("R7 inReady low when full", {31'd0, inReady}, 32'd0);
    repeat (3) @(negedge clk);
    checkEq("R7 inReady stays low", {31'd0, inReady}, 32'd0);
    drain();

    // R5: every slot, both dictionary entries
    for (int p = 0; p < 4; p++) sendVec(8'hA5 ^ (8'h02 << (2*p)), "R5");
    for (int p = 0; p < 4; p++) sendVec(8'h3C ^ (8'h03 << (2*p)), "R5");
    // R2 literals, R6 back to back
    sendVec(8'hFF, "R2");
    sendVec(8'h00, "R2");
    sendVec(8'h3C, "R6");
    sendVec(8'h5A, "R6");
    drain();

    // R9: write during a codeword is ignored
    sendBit(1'b0);
    sendBit(1'b1);
    dictWrite(1'b0, 8'h77, 0);
    expQ.push_back(8'hA5);
    tagQ.push_back("R9");
    sendBit(1'b0);
    drain();
    dictWrite(1'b0, 8'h77, 1);
    sendVec(8'h77, "R9");
    drain();

    // R1: reset drops partial codeword, keeps dictionary
    sendBit(1'b1);
    sendBit(1'b0);
    sendBit(1'b1);
    doReset();
    checkEq("R1 queue empty after mid-codeword reset", {31'd0, outValid}, 32'd0);
    sendVec(8'h3C, "R1");
    sendVec(8'h77, "R1");
    drain();

    // R6 random traffic with gaps and backpressure
    gapMode = 1;
    readyMode = 2;
    for (int n = 0; n < 300; n++) begin
      logic [7:0] v;
      int kind;
      kind = $urandom % 3;
      v = dictModel[$urandom % 2];
      if (kind == 1) v = v ^ (8'(($urandom % 3) + 1) << (2 * ($urandom % 4)));
      if (kind == 2) v = 8'($urandom);
      sendVec(v, "");
    end
    drain();
    checkEq("R7 scoreboard empty", expQ.size(), 32'd0);

    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule